// File: doc/BRIEF.md
# Mixed Time/Event Task Dispatcher

This block decides which task runs on one processing node. Two kinds of work share the processor. Time-triggered tasks start at fixed offsets that a static schedule table holds. Event-triggered tasks wait in a priority ready queue and run in the gaps between them. The block reads a free-running local time counter and walks the table in order. When an entry falls due, it starts that entry's task at once and displaces whatever was running.

Event-triggered tasks are numbered 0 to `NUM_ET-1`, and the number is also the priority: index 0 is the most urgent. An event pulse marks its task ready. When no time-triggered task holds the processor, the most urgent ready task is dispatched. A more urgent ready task takes over from a less urgent running one. A displaced event-triggered task goes back into the queue and resumes later.

The table is loaded through a simple write port. The repeat period is programmed as the least common multiple of the time-triggered periods, together with the count of valid entries. The processor reports completion with a single done pulse. Every displacement raises a one-cycle strobe that names the task that lost the processor.

Top module: `mixed_dispatcher`

## Requirements
- R1: While reset is applied and in the first cycle after it, no task is current (`curValid`=0) and `preemptPulse` is 0. The ready queue is empty and the table pointer starts at entry 0.
- R2: An entry whose start offset equals `localTime - frameStart` is due. Its task becomes current one clock later with `curIsTT`=1 and `curId` equal to the entry's task field. Here `frameStart` is 0 after reset and moves forward by `cfgPeriod` at each wrap.
- R3: Entries are taken strictly in address order, and each one fires at most once per period. An entry at address `cfgLen` or above never fires. When the offset reaches `cfgPeriod-1`, the pointer returns to entry 0 and `frameStart` moves forward by `cfgPeriod`, so the schedule repeats every `cfgPeriod` cycles.
- R4: A due time-triggered entry takes the processor even from a running event-triggered task that has not signalled done. That task's ready bit is set again.
- R5: A 1 on `eventReq[i]` makes task i ready one cycle later. An event for a task that is already ready is ignored, so that task is dispatched once, not twice.
- R6: An event-triggered task is dispatched only while no time-triggered task is current. The lowest ready index is chosen, and it is taken off the queue when it is dispatched.
- R7: If a ready task has a lower index than the running event-triggered task, the ready task takes over in the next cycle. The displaced task re-enters the ready queue.
- R8: When a running task is displaced before it reports done, `preemptPulse` is 1 for that one cycle. `preemptIsTT`/`preemptId` then name the outgoing task. Completion never raises the strobe.
- R9: `taskDone` (when no table entry falls due in the same cycle) leaves no task current in the next cycle. The next dispatch happens one cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| localTime | input | TIME_W | Free-running local time, one step per clock |
| cfgPeriod | input | TIME_W | Table repeat period in clocks |
| cfgLen | input | CNT_W | Number of valid table entries |
| tblWrEn | input | 1 | Table write strobe |
| tblWrAddr | input | PTR_W | Table entry to write |
| tblWrStart | input | TIME_W | Start offset of the written entry |
| tblWrTask | input | ID_W | Task number of the written entry |
| eventReq | input | NUM_ET | One bit per event-triggered task: its event occurred |
| taskDone | input | 1 | Current task completed |
| curValid | output | 1 | A task is current |
| curIsTT | output | 1 | Current task is time-triggered |
| curId | output | ID_W | Current task number |
| preemptPulse | output | 1 | A task was displaced this cycle |
| preemptIsTT | output | 1 | Displaced task was time-triggered |
| preemptId | output | ID_W | Displaced task number |

## Verification
The hidden state consists of the table pointer, the frame start, the ready bitmap and the running task. Each of these shows up at the outputs within one cycle of the decision that uses it. A slipped pointer or frame start moves a time-triggered start by at least one clock, or makes an entry fire twice or never. A lost or duplicated ready bit shows up as an event-triggered task that never runs again, or runs once too often. The outputs are compared every cycle over many table periods against a model built from the requirements, so any such error is caught at the first cycle where it changes the current task or the strobe.

// File: rtl/mixed_dispatcher_pkg.sv
package mixed_dispatcher_pkg;

  // Strobes from the control decision to the datapath registers.
  typedef struct packed {
    logic loadTT;      // start the due table task
    logic loadET;      // start the best ready event task
    logic clearRun;    // running task completed
    logic requeueRun;  // put running event task back in the queue
    logic preempt;     // running task displaced before completion
  } ctrl_t;

endpackage

// File: rtl/md_prio_pick.sv
module md_prio_pick #(
  parameter int N = 16,
  localparam int W = $clog2(N)
) (
  input  logic [N-1:0] req,
  output logic         any,
  output logic [W-1:0] idx
);

  // Lowest set index wins (index 0 is the most urgent).
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = W'(i);
    end
  end

  assign any = |req;

endmodule

// File: rtl/md_control.sv
module md_control
  import mixed_dispatcher_pkg::*;
#(
  parameter int ID_W = 4
) (
  input  logic            ttFire,
  input  logic            taskDone,
  input  logic            runValid,
  input  logic            runIsTT,
  input  logic [ID_W-1:0] runId,
  input  logic            anyReady,
  input  logic [ID_W-1:0] bestId,
  output ctrl_t           ctrl
);

  always_comb begin
    ctrl = '0;
    if (ttFire) begin
      // Table activation has absolute precedence.
      ctrl.loadTT = 1'b1;
      if (runValid && !taskDone) begin
        ctrl.preempt    = 1'b1;
        ctrl.requeueRun = !runIsTT;
      end
    end else if (taskDone) begin
      ctrl.clearRun = 1'b1;
    end else if (!(runValid && runIsTT) && anyReady) begin
      if (!runValid) begin
        ctrl.loadET = 1'b1;
      end else if (bestId < runId) begin
        ctrl.loadET     = 1'b1;
        ctrl.preempt    = 1'b1;
        ctrl.requeueRun = 1'b1;
      end
    end
  end

endmodule

// File: rtl/md_datapath.sv
module md_datapath
  import mixed_dispatcher_pkg::*;
#(
  parameter int NUM_ET    = 16,
  parameter int TIME_W    = 16,
  parameter int TBL_DEPTH = 8,
  localparam int ID_W  = $clog2(NUM_ET),
  localparam int PTR_W = $clog2(TBL_DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TIME_W-1:0] localTime,
  input  logic [TIME_W-1:0] cfgPeriod,
  input  logic [CNT_W-1:0]  cfgLen,
  input  logic              tblWrEn,
  input  logic [PTR_W-1:0]  tblWrAddr,
  input  logic [TIME_W-1:0] tblWrStart,
  input  logic [ID_W-1:0]   tblWrTask,
  input  logic [NUM_ET-1:0] eventReq,
  input  logic              taskDone,
  input  ctrl_t             ctrl,
  output logic              ttFire,
  output logic              anyReady,
  output logic [ID_W-1:0]   bestId,
  output logic              runValid,
  output logic              runIsTT,
  output logic [ID_W-1:0]   runId,
  output logic              preemptPulse,
  output logic              preemptIsTT,
  output logic [ID_W-1:0]   preemptId
);

  // Static schedule table
  logic [TIME_W-1:0] tblStart [TBL_DEPTH];
  logic [ID_W-1:0]   tblTask  [TBL_DEPTH];

  always_ff @(posedge clk) begin
    if (tblWrEn) begin
      tblStart[tblWrAddr] <= tblWrStart;
      tblTask[tblWrAddr]  <= tblWrTask;
    end
  end

  // Table walk
  logic [CNT_W-1:0]  ptr;
  logic [TIME_W-1:0] frameStart;
  logic [TIME_W-1:0] phase;
  logic              wrapNow;
  logic [ID_W-1:0]   ttTask;

  assign phase   = localTime - frameStart;
  assign ttTask  = tblTask[ptr[PTR_W-1:0]];
  assign ttFire  = (ptr < cfgLen) && (phase == tblStart[ptr[PTR_W-1:0]]);
  assign wrapNow = (phase == cfgPeriod - TIME_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr        <= '0;
      frameStart <= '0;
    end else if (wrapNow) begin
      ptr        <= '0;
      frameStart <= frameStart + cfgPeriod;
    end else if (ttFire) begin
      ptr <= ptr + CNT_W'(1);
    end
  end

  // Ready queue as a priority bitmap
  logic [NUM_ET-1:0] readyVec;
  logic [NUM_ET-1:0] readyNext;

  md_prio_pick #(.N(NUM_ET)) i_pick (
    .req (readyVec),
    .any (anyReady),
    .idx (bestId)
  );

  always_comb begin
    readyNext = readyVec;
    if (ctrl.loadET)     readyNext[bestId] = 1'b0;
    if (ctrl.requeueRun) readyNext[runId]  = 1'b1;
    readyNext = readyNext | eventReq;
  end

  // Running task and displacement report
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readyVec     <= '0;
      runValid     <= 1'b0;
      runIsTT      <= 1'b0;
      runId        <= '0;
      preemptPulse <= 1'b0;
      preemptIsTT  <= 1'b0;
      preemptId    <= '0;
    end else begin
      readyVec     <= readyNext;
      preemptPulse <= ctrl.preempt;
      if (ctrl.preempt) begin
        preemptIsTT <= runIsTT;
        preemptId   <= runId;
      end
      if (ctrl.loadTT) begin
        runValid <= 1'b1;
        runIsTT  <= 1'b1;
        runId    <= ttTask;
      end else if (ctrl.loadET) begin
        runValid <= 1'b1;
        runIsTT  <= 1'b0;
        runId    <= bestId;
      end else if (ctrl.clearRun) begin
        runValid <= 1'b0;
      end
    end
  end

  // Assertions
  p_tt_start_r2: assert property (@(posedge clk) disable iff (!rstN)
    ttFire |=> runValid && runIsTT && (runId == $past(ttTask)));

  p_ptr_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    ptr <= CNT_W'(TBL_DEPTH));

  p_requeue_on_tt_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ttFire && runValid && !runIsTT && !taskDone) |=> readyVec[$past(runId)]);

  p_event_lands_r5: assert property (@(posedge clk) disable iff (!rstN)
    (eventReq != '0) |=> ((readyVec & $past(eventReq)) == $past(eventReq)));

  p_no_spurious_ready_r5: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ($countones(readyVec & ~$past(readyVec) & ~$past(eventReq)) <= 1));

  p_tt_holds_r6: assert property (@(posedge clk) disable iff (!rstN)
    (runValid && runIsTT && !ttFire && !taskDone) |=>
      runValid && runIsTT && $stable(runId));

  p_strobe_cause_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(preemptPulse) |-> $past(runValid) && !$past(taskDone));

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    (taskDone && !ttFire) |=> !runValid);

endmodule

// File: rtl/mixed_dispatcher.sv
module mixed_dispatcher
  import mixed_dispatcher_pkg::*;
#(
  parameter int NUM_ET    = 16,
  parameter int TIME_W    = 16,
  parameter int TBL_DEPTH = 8,
  localparam int ID_W  = $clog2(NUM_ET),
  localparam int PTR_W = $clog2(TBL_DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TIME_W-1:0] localTime,
  input  logic [TIME_W-1:0] cfgPeriod,
  input  logic [CNT_W-1:0]  cfgLen,
  input  logic              tblWrEn,
  input  logic [PTR_W-1:0]  tblWrAddr,
  input  logic [TIME_W-1:0] tblWrStart,
  input  logic [ID_W-1:0]   tblWrTask,
  input  logic [NUM_ET-1:0] eventReq,
  input  logic              taskDone,
  output logic              curValid,
  output logic              curIsTT,
  output logic [ID_W-1:0]   curId,
  output logic              preemptPulse,
  output logic              preemptIsTT,
  output logic [ID_W-1:0]   preemptId
);

  ctrl_t           ctrl;
  logic            ttFire;
  logic            anyReady;
  logic [ID_W-1:0] bestId;

  md_control #(.ID_W(ID_W)) i_control (
    .ttFire   (ttFire),
    .taskDone (taskDone),
    .runValid (curValid),
    .runIsTT  (curIsTT),
    .runId    (curId),
    .anyReady (anyReady),
    .bestId   (bestId),
    .ctrl     (ctrl)
  );

  md_datapath #(
    .NUM_ET    (NUM_ET),
    .TIME_W    (TIME_W),
    .TBL_DEPTH (TBL_DEPTH)
  ) i_datapath (
    .clk          (clk),
    .rstN         (rstN),
    .localTime    (localTime),
    .cfgPeriod    (cfgPeriod),
    .cfgLen       (cfgLen),
    .tblWrEn      (tblWrEn),
    .tblWrAddr    (tblWrAddr),
    .tblWrStart   (tblWrStart),
    .tblWrTask    (tblWrTask),
    .eventReq     (eventReq),
    .taskDone     (taskDone),
    .ctrl         (ctrl),
    .ttFire       (ttFire),
    .anyReady     (anyReady),
    .bestId       (bestId),
    .runValid     (curValid),
    .runIsTT      (curIsTT),
    .runId        (curId),
    .preemptPulse (preemptPulse),
    .preemptIsTT  (preemptIsTT),
    .preemptId    (preemptId)
  );

endmodule

// File: tb/test_mixed_dispatcher.sv
`timescale 1ns/1ps
module test_mixed_dispatcher;

  localparam int NUM_ET = 16;
  localparam int TIME_W = 16;
  localparam int DEPTH  = 8;
  localparam int ID_W   = 4;
  localparam int PERIOD = 40;
  localparam int LEN    = 3;
  localparam int CYCLES = 3000;

  logic              clk = 1'b0;
  logic              rstN;
  logic [TIME_W-1:0] localTime;
  logic [TIME_W-1:0] cfgPeriod;
  logic [3:0]        cfgLen;
  logic              tblWrEn;
  logic [2:0]        tblWrAddr;
  logic [TIME_W-1:0] tblWrStart;
  logic [ID_W-1:0]   tblWrTask;
  logic [NUM_ET-1:0] eventReq;
  logic              taskDone;
  logic              curValid, curIsTT, preemptPulse, preemptIsTT;
  logic [ID_W-1:0]   curId, preemptId;

  always #2.5 clk = ~clk;

  always_ff @(posedge clk) begin
    if (!rstN) localTime <= '0;
    else       localTime <= localTime + TIME_W'(1);
  end

  mixed_dispatcher i_mixed_dispatcher (
    .clk(clk), .rstN(rstN), .localTime(localTime), .cfgPeriod(cfgPeriod),
    .cfgLen(cfgLen), .tblWrEn(tblWrEn), .tblWrAddr(tblWrAddr),
    .tblWrStart(tblWrStart), .tblWrTask(tblWrTask), .eventReq(eventReq),
    .taskDone(taskDone), .curValid(curValid), .curIsTT(curIsTT),
    .curId(curId), .preemptPulse(preemptPulse), .preemptIsTT(preemptIsTT),
    .preemptId(preemptId)
  );

  int  nChecks = 0;
  int  nFails  = 0;
  bit  finished = 0;

  // Table contents (entries at LEN and above must never fire)
  int tStart [DEPTH];
  int tTask  [DEPTH];

  // Requirement-level model state
  logic              mValid, mIsTT, mPulse, mPIsTT;
  int                mId, mPId, mPtr;
  logic [TIME_W-1:0] mBase;
  logic [NUM_ET-1:0] mReady;
  string             tag;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic compareOutputs();
    chk(curValid == mValid, tag, "curValid", int'(curValid), int'(mValid));
    if (mValid) begin
      chk(curIsTT == mIsTT, tag, "curIsTT", int'(curIsTT), int'(mIsTT));
      chk(int'(curId) == mId, tag, "curId", int'(curId), mId);
    end
    chk(preemptPulse == mPulse, "R8", "preemptPulse", int'(preemptPulse), int'(mPulse));
    if (mPulse) begin
      chk(preemptIsTT == mPIsTT, "R8", "preemptIsTT", int'(preemptIsTT), int'(mPIsTT));
      chk(int'(preemptId) == mPId, "R8", "preemptId", int'(preemptId), mPId);
    end
  endtask

  task automatic modelStep(input logic [TIME_W-1:0] t,
                           input logic [NUM_ET-1:0] ev, input logic dn);
    logic [TIME_W-1:0] ph;
    logic [NUM_ET-1:0] r;
    logic fire, found;
    int best;
    ph = t - mBase;
    r = mReady;
    fire = (mPtr < LEN) && (int'(ph) == tStart[mPtr]);
    found = 1'b0;
    best = 0;
    for (int i = 0; i < NUM_ET; i++) begin
      if (!found && mReady[i]) begin found = 1'b1; best = i; end
    end
    mPulse = 1'b0;
    tag = "R6";
    if (fire) begin
      tag = "R2";
      if (mValid && !dn) begin
        mPulse = 1'b1; mPIsTT = mIsTT; mPId = mId;
        if (!mIsTT) begin r[mId] = 1'b1; tag = "R4"; end
      end
      mValid = 1'b1; mIsTT = 1'b1; mId = tTask[mPtr];
    end else if (dn) begin
      mValid = 1'b0; tag = "R9";
    end else if (mValid && mIsTT) begin
      tag = found ? "R6" : "R2";
    end else if (found) begin
      if (!mValid) begin
        r[best] = 1'b0; mValid = 1'b1; mIsTT = 1'b0; mId = best; tag = "R6";
      end else if (best < mId) begin
        mPulse = 1'b1; mPIsTT = 1'b0; mPId = mId;
        r[mId] = 1'b1; r[best] = 1'b0; mId = best; tag = "R7";
      end
    end
    if ((mReady & ev) != '0) tag = "R5";
    mReady = r | ev;
    if (int'(ph) == tStart[LEN]) tag = "R3";
    if (int'(ph) == PERIOD - 1) begin
      mBase = mBase + TIME_W'(PERIOD); mPtr = 0; tag = "R3";
    end else if (fire) begin
      mPtr++;
    end
  endtask

  initial begin
    logic [31:0] rnd;
    logic [TIME_W-1:0] tNow;
    logic [NUM_ET-1:0] evNow;
    logic dnNow;
    rnd = 32'h1badf00d;
    tStart[0] = 3;  tTask[0] = 1;
    tStart[1] = 15; tTask[1] = 2;
    tStart[2] = 28; tTask[2] = 9;
    for (int i = LEN; i < DEPTH; i++) begin tStart[i] = 35 + i - LEN; tTask[i] = 4; end
    rstN = 1'b0; eventReq = '0; taskDone = 1'b0; tblWrEn = 1'b0;
    tblWrAddr = '0; tblWrStart = '0; tblWrTask = '0;
    cfgPeriod = TIME_W'(PERIOD); cfgLen = 4'(LEN);
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      tblWrEn = 1'b1; tblWrAddr = 3'(i);
      tblWrStart = TIME_W'(tStart[i]); tblWrTask = ID_W'(tTask[i]);
    end
    @(negedge clk);
    tblWrEn = 1'b0;
    repeat (2) @(negedge clk);
    // R1: idle while reset is held
    chk(curValid == 1'b0, "R1", "curValid in reset", int'(curValid), 0);
    chk(preemptPulse == 1'b0, "R1", "preemptPulse in reset", int'(preemptPulse), 0);
    rstN = 1'b1;
    mValid = 1'b0; mIsTT = 1'b0; mId = 0; mPulse = 1'b0; mPIsTT = 1'b0;
    mPId = 0; mPtr = 0; mBase = '0; mReady = '0; tag = "R1";
    for (int cyc = 0; cyc < CYCLES; cyc++) begin
      compareOutputs();
      rnd = rnd ^ (rnd << 13); rnd = rnd ^ (rnd >> 17); rnd = rnd ^ (rnd << 5);
      eventReq = '0;
      if (rnd[1:0] == 2'd0) eventReq[rnd[7:4]] = 1'b1;
      if (rnd[15:12] == 4'd0) eventReq[rnd[19:16]] = 1'b1;
      taskDone = mValid && (rnd[10:9] == 2'd0);
      tNow = localTime; evNow = eventReq; dnNow = taskDone;
      @(posedge clk);
      modelStep(tNow, evNow, dnNow);
      @(negedge clk);
    end
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule